// File: doc/BRIEF.md
# Converter Result Holding Stage with Window Compare

This block sits behind a successive-approximation converter and decides what software sees of each finished conversion. A one-cycle `conv_done` strobe brings in a raw result. The block may move that result into two byte-wide result registers. The move depends on the selected resolution, an optional automatic compare against a programmed level, and a read interlock. In wide (10-bit) resolution, software must read the upper byte first and then the lower byte. The interlock keeps the pair consistent during that sequence. A sticky flag records that a new result has landed.

The interlock is a two-state machine. In state `LK_OPEN`, results transfer freely. Transition `T_LOCK` moves it to `LK_HELD` when the upper byte is read in wide resolution. Transition `T_FREE` returns it to `LK_OPEN` when the lower byte is read or the resolution changes. The machine never leaves `LK_OPEN` in narrow (8-bit) resolution. A change of resolution is detected against a registered copy of the mode. That change clears the stored result, the flag and the lock on the next clock edge.

The lock state before an edge decides whether a conversion arriving at that edge is accepted. A conversion that arrives together with an upper-byte read is therefore kept. A conversion that arrives together with the releasing lower-byte read is dropped.

Top module: `adc_result_hold`

## Requirements
- R1: After reset both result bytes read 0x00, `done_flag` is 0 and the interlock is open.
- R2: Bits 7:2 of `res_hi` always read zero. In wide mode (`mode_10b`=1) an accepted conversion places `conv_raw[9:8]` in `res_hi[1:0]` and `conv_raw[7:0]` in `res_lo`.
- R3: In narrow mode (`mode_10b`=0) the 8-bit result is taken from `conv_raw[7:0]`. `conv_raw[9:8]` is ignored, and `res_hi` reads 0x00 after any accepted conversion.
- R4: With `cmp_en`=0 every conversion strobe in `LK_OPEN` updates both bytes, and the new value is visible in the cycle after the strobe.
- R5: With `cmp_en`=1 a conversion is transferred only when the compare condition holds. Otherwise both bytes keep their previous values.
- R6: With `cmp_ge`=0 the condition is result < `cmp_level`. With `cmp_ge`=1 it is result >= `cmp_level`. Wide mode compares all 10 bits. Narrow mode compares `conv_raw[7:0]` with `cmp_level[7:0]`.
- R7: In wide mode a `rd_hi` strobe locks the registers. Conversions completing while locked are discarded and never become visible. A `rd_lo` strobe releases the lock, and the next conversion transfers.
- R8: In narrow mode read strobes never lock, so a conversion after `rd_hi` still transfers.
- R9: A change of `mode_10b` clears both bytes, clears `done_flag` and releases the lock one edge later. A conversion strobe at that edge is dropped.
- R10: `done_flag` sets when a result is transferred and clears on `rd_lo`. If both happen at the same edge, the set wins.
- R11: A conversion strobe at the same edge as `rd_hi` is accepted. A conversion strobe at the same edge as the releasing `rd_lo` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_raw | input | 10 | Raw conversion result |
| mode_10b | input | 1 | 1 = 10-bit resolution, 0 = 8-bit |
| cmp_en | input | 1 | Enable automatic compare gating |
| cmp_ge | input | 1 | Compare direction: 1 = greater or equal, 0 = less than |
| cmp_level | input | 10 | Compare level |
| rd_hi | input | 1 | Read strobe for the upper result byte |
| rd_lo | input | 1 | Read strobe for the lower result byte |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |
| done_flag | output | 1 | Sticky new-result flag |

## Verification
Every result and flag change lands one register stage after the strobe that causes it. A conversion or read strobe sampled at one rising edge is visible in the period that follows. A mode change clears the registers at the first edge after `mode_10b` moves.

The bench drives every input on a falling edge, so one rising edge falls in between. It compares outputs on the next falling edge, half a period after the edge that updated them. The same-edge cases of R10 and R11 put both strobes in a single driven cycle so that they are sampled at one edge.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

    typedef enum logic [0:0] {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/adc_res_cmp.sv
module adc_res_cmp #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0] raw,
    input  logic [RES_W-1:0] level,
    input  logic             wide_mode,
    input  logic             ge_sel,
    output logic             hit
);
    logic [RES_W-1:0] a_val;
    logic [RES_W-1:0] b_val;

    always_comb begin
        if (wide_mode) begin
            a_val = raw;
            b_val = level;
        end else begin
            a_val = {{(RES_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
            b_val = {{(RES_W-BYTE_W){1'b0}}, level[BYTE_W-1:0]};
        end
        hit = ge_sel ? (a_val >= b_val) : (a_val < b_val);
    end

endmodule

// File: rtl/adc_res_lock.sv
module adc_res_lock
    import adc_res_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wide_mode,
    input  logic mode_flip,
    input  logic rd_hi,
    input  logic rd_lo,
    output logic held
);
    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (!mode_flip && wide_mode && rd_hi) state_d = LK_HELD;  // T_LOCK
            LK_HELD: if (mode_flip || rd_lo)              state_d = LK_OPEN;  // T_FREE
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        held = (state_q == LK_HELD);
    end

endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_flip,
    input  logic                    wide_mode,
    input  logic                    load,
    input  logic [RES_W-1:0]        raw,
    input  logic                    rd_lo,
    output logic [RES_W-BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0]       lo_q,
    output logic                    flag_q
);
    localparam int HI_W = RES_W - BYTE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            flag_q <= 1'b0;
        end else if (mode_flip) begin
            hi_q   <= '0;
            lo_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load) begin
                hi_q   <= wide_mode ? raw[RES_W-1:BYTE_W] : {HI_W{1'b0}};
                lo_q   <= raw[BYTE_W-1:0];
                flag_q <= 1'b1;
            end else if (rd_lo) begin
                flag_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_raw,
    input  logic              mode_10b,
    input  logic              cmp_en,
    input  logic              cmp_ge,
    input  logic [RES_W-1:0]  cmp_level,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done_flag
);
    localparam int HI_W = RES_W - BYTE_W;

    logic            mode_q;
    logic            mode_flip;
    logic            cmp_hit;
    logic            lock_held;
    logic            accept;
    logic [HI_W-1:0] hi_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_10b;
    end

    assign mode_flip = (mode_10b != mode_q);

    adc_res_cmp #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_cmp (
        .raw       (conv_raw),
        .level     (cmp_level),
        .wide_mode (mode_10b),
        .ge_sel    (cmp_ge),
        .hit       (cmp_hit)
    );

    adc_res_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (mode_10b),
        .mode_flip (mode_flip),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .held      (lock_held)
    );

    assign accept = conv_done && !lock_held && !mode_flip && (!cmp_en || cmp_hit);

    adc_res_store #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_flip (mode_flip),
        .wide_mode (mode_10b),
        .load      (accept),
        .raw       (conv_raw),
        .rd_lo     (rd_lo),
        .hi_q      (hi_bits),
        .lo_q      (res_lo),
        .flag_q    (done_flag)
    );

    assign res_hi = {{(BYTE_W-HI_W){1'b0}}, hi_bits};

endmodule

// File: rtl/adc_result_hold_chk.sv
module adc_result_hold_chk #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [RES_W-1:0]  conv_raw,
    input logic              mode_10b,
    input logic              mode_q,
    input logic              cmp_en,
    input logic              rd_lo,
    input logic              held,
    input logic [BYTE_W-1:0] res_hi,
    input logic [BYTE_W-1:0] res_lo,
    input logic              done_flag
);
    localparam int HI_W = RES_W - BYTE_W;

    logic [BYTE_W-1:0] raw_lo;
    assign raw_lo = conv_raw[BYTE_W-1:0];

    a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi[BYTE_W-1:HI_W] == '0);

    a_r3_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10b |=> (res_hi == '0));

    a_r4_plain_update: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cmp_en && !held && (mode_10b == mode_q)) |=> (res_lo == $past(raw_lo)));

    a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rd_lo && (mode_10b == mode_q)) |=> ($stable(res_lo) && $stable(res_hi)));

    a_r8_narrow_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10b |=> !held);

    a_r9_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_10b != mode_q) |=> (res_lo == '0 && res_hi == '0 && !done_flag && !held));

    a_r10_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> ($past(rd_lo) || ($past(mode_10b) != $past(mode_q))));

endmodule

bind adc_result_hold adc_result_hold_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_raw  (conv_raw),
    .mode_10b  (mode_10b),
    .mode_q    (mode_q),
    .cmp_en    (cmp_en),
    .rd_lo     (rd_lo),
    .held      (lock_held),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .done_flag (done_flag)
);

// File: tb/sim_adc_result_hold.sv
`timescale 1ns/1ps
module sim_adc_result_hold;

    typedef struct packed {
        logic       m;
        logic       en;
        logic       ge;
        logic [9:0] lvl;
        logic [9:0] raw;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 10'h000, 10'h3A5, 8'h00, 8'hA5},  // R3 R4
        '{1'b0, 1'b1, 1'b0, 10'h050, 10'h040, 8'h00, 8'h40},  // R5 R6 lt true
        '{1'b0, 1'b1, 1'b0, 10'h050, 10'h060, 8'h00, 8'h40},  // R5 lt false
        '{1'b0, 1'b1, 1'b1, 10'h230, 10'h160, 8'h00, 8'h60},  // R6 low 8 bits only
        '{1'b1, 1'b0, 1'b0, 10'h000, 10'h2C7, 8'h02, 8'hC7},  // R2 wide
        '{1'b1, 1'b1, 1'b1, 10'h200, 10'h1FF, 8'h02, 8'hC7},  // R5 ge false
        '{1'b1, 1'b1, 1'b1, 10'h200, 10'h200, 8'h02, 8'h00},  // R6 ge equal
        '{1'b1, 1'b1, 1'b0, 10'h100, 10'h0FF, 8'h00, 8'hFF},  // R6 lt true
        '{1'b1, 1'b1, 1'b0, 10'h100, 10'h100, 8'h00, 8'hFF}   // R6 lt equal false
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_raw = '0;
    logic       mode_10b = 1'b0;
    logic       cmp_en = 1'b0;
    logic       cmp_ge = 1'b0;
    logic [9:0] cmp_level = '0;
    logic       rd_hi = 1'b0;
    logic       rd_lo = 1'b0;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       done_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_result_hold u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_raw  (conv_raw),
        .mode_10b  (mode_10b),
        .cmp_en    (cmp_en),
        .cmp_ge    (cmp_ge),
        .cmp_level (cmp_level),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .done_flag (done_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit cv, input logic [9:0] raw, input bit hi, input bit lo);
        @(negedge clk);
        conv_done = cv;
        conv_raw  = raw;
        rd_hi     = hi;
        rd_lo     = lo;
        @(negedge clk);
        conv_done = 1'b0;
        rd_hi     = 1'b0;
        rd_lo     = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        mode_10b = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hi", res_hi, 8'h00);
        chk("R1 lo", res_lo, 8'h00);
        chk("R1 flag", {7'd0, done_flag}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].m != mode_10b) begin
                set_mode(VEC[i].m);
                chk("R9 hi clear", res_hi, 8'h00);
                chk("R9 lo clear", res_lo, 8'h00);
                chk("R9 flag clear", {7'd0, done_flag}, 8'h00);
            end
            cmp_en    = VEC[i].en;
            cmp_ge    = VEC[i].ge;
            cmp_level = VEC[i].lvl;
            pulse(1'b1, VEC[i].raw, 1'b0, 1'b0);
            chk($sformatf("R2 R5 R6 vec%0d hi", i), res_hi, VEC[i].hi);
            chk($sformatf("R4 R5 R6 vec%0d lo", i), res_lo, VEC[i].lo);
        end

        // R7 interlock in wide mode, R10 flag
        cmp_en = 1'b0;
        pulse(1'b0, 10'h000, 1'b1, 1'b0);
        pulse(1'b1, 10'h3C3, 1'b0, 1'b0);
        chk("R7 held lo", res_lo, 8'hFF);
        chk("R7 held hi", res_hi, 8'h00);
        pulse(1'b0, 10'h000, 1'b0, 1'b1);
        chk("R10 flag cleared", {7'd0, done_flag}, 8'h00);
        pulse(1'b1, 10'h3C3, 1'b0, 1'b0);
        chk("R7 released hi", res_hi, 8'h03);
        chk("R7 released lo", res_lo, 8'hC3);
        chk("R10 flag set", {7'd0, done_flag}, 8'h01);

        // R11 same-edge ordering
        pulse(1'b1, 10'h155, 1'b1, 1'b0);
        chk("R11 conv with rd_hi hi", res_hi, 8'h01);
        chk("R11 conv with rd_hi lo", res_lo, 8'h55);
        pulse(1'b1, 10'h0AA, 1'b0, 1'b0);
        chk("R11 locked after rd_hi", res_lo, 8'h55);
        pulse(1'b1, 10'h0AA, 1'b0, 1'b1);
        chk("R11 conv with releasing rd_lo", res_lo, 8'h55);
        chk("R10 flag cleared no xfer", {7'd0, done_flag}, 8'h00);
        pulse(1'b1, 10'h0AA, 1'b0, 1'b0);
        chk("R11 open again", res_lo, 8'hAA);

        // R10 set wins over clear
        pulse(1'b1, 10'h011, 1'b0, 1'b1);
        chk("R10 set wins", {7'd0, done_flag}, 8'h01);
        chk("R10 data", res_lo, 8'h11);

        // R9 mode change releases lock
        pulse(1'b0, 10'h000, 1'b1, 1'b0);
        set_mode(1'b0);
        chk("R9 clear lo", res_lo, 8'h00);
        chk("R9 flag", {7'd0, done_flag}, 8'h00);
        pulse(1'b1, 10'h1EE, 1'b0, 1'b0);
        chk("R9 lock released", res_lo, 8'hEE);

        // R8 no lock in narrow mode, R3 upper bits ignored
        pulse(1'b0, 10'h000, 1'b1, 1'b0);
        pulse(1'b1, 10'h2BB, 1'b0, 1'b0);
        chk("R8 narrow not locked", res_lo, 8'hBB);
        chk("R3 hi zero", res_hi, 8'h00);

        // R9 conversion on the mode-change edge is dropped
        @(negedge clk);
        mode_10b  = 1'b1;
        conv_done = 1'b1;
        conv_raw  = 10'h3FF;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R9 drop on flip lo", res_lo, 8'h00);
        chk("R9 drop on flip hi", res_hi, 8'h00);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule